// File: doc/BRIEF.md
# OTG Timeout One-Shot Timer

This block measures a single protocol interval for the on-the-go controller of a USB device. Software writes one 32-bit control word. Its top bit arms the timer, and its low 27 bits give a duration in ticks of the device clock. While armed, the timer counts down. When the count runs out, the block zeroes its readable word and emits a one-cycle timeout event. A neighbouring interrupt block latches that event into bit 16 of its main pending register.

A later write always takes precedence over the countdown in progress. A new armed word restarts the countdown from its own count. A word with the top bit clear disarms the timer, and no event follows. The timer never reloads by itself: each timeout needs a fresh armed write.

Top module: `otg_timeout_timer`

## Requirements
- R1: After synchronous reset, rd_data is 0 and timeout_pulse stays low as long as no armed word is written.
- R2: A write stores all 32 bits of wr_data, and rd_data shows that word from the cycle after the write edge until expiry or the next write.
- R3: A write at clock edge E with bit 31 set and a count N ≥ 1 in bits 26:0 expires at edge E+N; timeout_pulse is high in the cycle after that edge.
- R4: An armed write with a count of 0 expires at the next clock edge, exactly like a count of 1.
- R5: At the expiry edge, rd_data becomes 0 in the same cycle that timeout_pulse is high.
- R6: A write with bit 31 clear cancels any pending expiry, so no pulse follows. rd_data keeps the written word.
- R7: An armed write while the timer is running drops the old count, and expiry follows R3 measured from the new write only.
- R8: timeout_pulse lasts exactly one cycle, and an expired timer produces no further pulse until it is armed again.
- R9: A write on the same edge as a pending expiry wins. That expiry is suppressed and the written word is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock; one tick per period |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word: bit 31 arm, bits 26:0 tick count |
| rd_data | output | 32 | Readable control word |
| timeout_pulse | output | 1 | One-cycle timeout event |

## Verification
The countdown is driven with counts of 0, 1, small values and a count in the thousands. Comparing 0 with 1 shows whether zero is treated as the shortest interval. The small and large counts expose off-by-one errors and borrow faults in the decrement. Disarming writes, armed rewrites in mid-count, and a rewrite placed exactly on the expiry edge show whether a write correctly overrides the countdown and the clearing of the readable word. Words with the unused bits 30:27 set show that the full word is stored and then zeroed.

// File: rtl/otg_tmr_pkg.sv
package otg_tmr_pkg;
  // Countdown state of the one-shot timer.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/otg_tmr_down_cnt.sv
// Arming logic and tick counter. Expiry is flagged combinationally on the
// edge at which the count reaches its end; a load on that edge wins.
module otg_tmr_down_cnt
  import otg_tmr_pkg::*;
#(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             load_arm,
  input  logic [CNT_W-1:0] load_cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  tmr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_tick;

  // Counts of 0 and 1 both end on the next tick.
  assign last_tick = (cnt_q[CNT_W-1:1] == '0);
  assign expire    = (state_q == ST_RUN) && last_tick && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= ZERO;
    end else if (load) begin
      state_q <= load_arm ? ST_RUN : ST_IDLE;
      cnt_q   <= load_cnt;
    end else if (expire) begin
      state_q <= ST_IDLE;
      cnt_q   <= ZERO;
    end else if (state_q == ST_RUN) begin
      cnt_q   <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/otg_tmr_ctrl_reg.sv
// Readable control word: loaded by writes, cleared on expiry.
module otg_tmr_ctrl_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clear,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_en) begin
      q <= wr_data;
    end else if (clear) begin
      q <= '0;
    end
  end
endmodule

// File: rtl/otg_tmr_pulse.sv
// Registers the expiry strobe into a one-cycle event output.
module otg_tmr_pulse (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= fire;
  end
endmodule

// File: rtl/otg_timeout_timer.sv
module otg_timeout_timer #(
  parameter int DATA_W = 32,
  parameter int ARM_BIT = 31,
  parameter int CNT_W  = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              timeout_pulse
);
  logic expire;

  otg_tmr_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_en),
    .load_arm (wr_data[ARM_BIT]),
    .load_cnt (wr_data[CNT_W-1:0]),
    .expire   (expire)
  );

  otg_tmr_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .clear   (expire),
    .q       (rd_data)
  );

  otg_tmr_pulse u_evt (
    .clk   (clk),
    .rst   (rst),
    .fire  (expire),
    .pulse (timeout_pulse)
  );
endmodule

// File: rtl/otg_tmr_chk.sv
module otg_tmr_chk #(
  parameter int DATA_W = 32,
  parameter int ARM_BIT = 31,
  parameter int CNT_W  = 27
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              timeout_pulse
);
  // R2: the written word is visible on the following cycle
  a_r2_word_visible: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data == $past(wr_data)));

  // R5: the readable word is zero whenever the event is high
  a_r5_zero_on_event: assert property (@(posedge clk) disable iff (rst)
    timeout_pulse |-> (rd_data == '0));

  // R6: a disarming write is never followed by an event
  a_r6_cancel_quiet: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[ARM_BIT]) |=> !timeout_pulse);

  // R8: the event lasts a single cycle
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
    timeout_pulse |=> !timeout_pulse);

  // R4: an armed count of 0 or 1 fires after exactly one tick
  a_r4_shortest: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[ARM_BIT] && (wr_data[CNT_W-1:1] == '0)) ##1 !wr_en
      |=> timeout_pulse);
endmodule

bind otg_timeout_timer otg_tmr_chk #(
  .DATA_W(DATA_W), .ARM_BIT(ARM_BIT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .timeout_pulse(timeout_pulse)
);

// File: tb/sim_otg_timeout_timer.sv
module sim_otg_timeout_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        timeout_pulse;

  int    cyc = 0;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // Scoreboard: cycle numbers at which an event is expected.
  int          sb[$];
  logic [31:0] exp_rd = '0;
  logic [31:0] pend_rd = '0;
  int          pend_cyc = -1;

  otg_timeout_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .timeout_pulse(timeout_pulse)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Driver: presents one write for one edge and records expectations.
  task automatic drive_write(input logic [31:0] v);
    int n;
    @(negedge clk); #1;
    wr_en = 1'b1;
    wr_data = v;
    pend_rd = v;
    pend_cyc = cyc + 1;
    sb.delete();
    if (v[31]) begin
      n = int'(v[26:0]);
      if (n == 0) n = 1;
      sb.push_back(cyc + 1 + n);
    end
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: samples away from the active edge and compares.
  always @(negedge clk) begin
    logic exp_p;
    if (!rst && !done) begin
      if (cyc == pend_cyc) exp_rd = pend_rd;
      exp_p = 1'b0;
      if (sb.size() > 0 && sb[0] == cyc) begin
        exp_p = 1'b1;
        exp_rd = '0;
        void'(sb.pop_front());
      end
      n_vec++;
      if (timeout_pulse !== exp_p) begin
        n_bad++;
        $display("FAIL %s cyc %0d timeout_pulse actual %b expected %b",
                 cur_req, cyc, timeout_pulse, exp_p);
      end
      n_vec++;
      if (rd_data !== exp_rd) begin
        n_bad++;
        $display("FAIL %s cyc %0d rd_data actual %h expected %h",
                 cur_req, cyc, rd_data, exp_rd);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); #1 rst = 1'b0;
    cur_req = "R1"; idle(20);                 // R1: quiet after reset
    cur_req = "R2"; drive_write(32'h1234_5678); idle(5);
    drive_write(32'h7ABC_DEF0); idle(5);      // R2: full word, unused bits too
    cur_req = "R3"; drive_write(32'h8000_0005); idle(12);
    drive_write(32'h8000_0001); idle(6);
    drive_write(32'h8000_0064); idle(110);
    drive_write(32'h8000_07D0); idle(2010);   // R3: long count
    cur_req = "R4"; drive_write(32'h8000_0000); idle(6);
    drive_write(32'hF800_0000); idle(6);      // R4 with bits 30:27 set, R5
    cur_req = "R5"; drive_write(32'hC000_0003); idle(8);
    cur_req = "R6"; drive_write(32'h8000_0032); idle(10);
    drive_write(32'h0000_0032); idle(80);     // R6: cancelled, word kept
    cur_req = "R7"; drive_write(32'h8000_0028); idle(10);
    drive_write(32'h8000_0008); idle(60);     // R7: only new timing
    cur_req = "R9"; drive_write(32'h8000_0003); idle(1);
    drive_write(32'h8000_0014); idle(30);     // R9: write on expiry edge
    cur_req = "R8"; drive_write(32'h8000_0002); idle(200); // R8: no re-fire
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule